// File: doc/BRIEF.md
# Bit-Serial EEPROM Command Engine

This block acts as a small serial EEPROM placed behind a host bus. The host moves one bit per bus access. A write strobe delivers one input bit, taken from bit 0 of the write data. A read strobe returns one output bit. A command starts with a two-bit opcode. A six-bit block number follows, and it selects one of 64 eight-byte blocks in a 512-byte on-chip store.

A write command carries 64 data bits and then a stop bit. The 64 bits are committed to the selected block. A read command ends with a stop bit. The host then collects four dummy bits and, after them, the 64 bits of the block. When no block is being sent out, a read strobe returns a ready flag instead. That flag tells the host whether the last write has completed.

A restart request puts the engine back to waiting for an opcode. The engine follows that request only while it is not transmitting. After reset, the engine spends `BLOCKS` clock cycles writing zeros to the store. The host must not start a command before that time has passed.

Top module: `serial_eeprom_engine`

## Requirements
- R1: Only bit 0 of `wr_data_i` is used as the serial input bit. Bits 15..1 have no effect on any stored or returned value.
- R2: The opcode is two bits, first bit most significant. 2'b11 starts a read and 2'b10 starts a write. Any other opcode discards the bits and waits for a new opcode.
- R3: After the opcode, exactly six bits are collected, most significant first. They form the block number N, whose bytes sit at byte addresses 8*N to 8*N+7. Blocks 0 and 63 are both reachable.
- R4: A write command collects exactly 64 data bits, most significant first. The first byte received is stored as byte 0 of the block and the last byte as byte 7. The ready flag is cleared as soon as the write's block number has been received.
- R5: The bit after the 64 write data bits is a stop bit. Its value is ignored. It sets the ready flag, and the engine then waits for a new opcode.
- R6: A read command takes one stop bit after its block number. The next four read strobes each return 0.
- R7: The next 64 read strobes return the block, most significant bit first, so that byte 0 comes out first. After the 64th bit the engine waits for a new opcode.
- R8: A read strobe outside the dummy and data output phases returns the ready flag. The flag is 0 after reset and stays 0 until a write has completed.
- R9: `xmit_o` is 1 exactly during the dummy and data output phases and 0 at all other times, including the time after reset.
- R10: A restart request while `xmit_o` is 0 aborts any partial command, clears the bit counters and waits for an opcode. It changes neither the store nor the ready flag. While `xmit_o` is 1, the request is ignored.
- R11: Write strobes during the dummy and data output phases are ignored.
- R12: After reset, every block reads back as all zeros until it is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; starts the zero-fill of the store |
| restart_i | input | 1 | Request to return to opcode reception; ignored while transmitting |
| wr_stb_i | input | 1 | Host write strobe; one serial input bit per cycle it is high |
| wr_data_i | input | BUS_W | Host write data; only bit 0 is used |
| rd_stb_i | input | 1 | Host read strobe; one output bit per cycle it is high |
| rd_bit_o | output | 1 | Registered output bit, updated on the edge that samples `rd_stb_i` |
| xmit_o | output | 1 | High during the dummy and data output phases |

## Verification
The bench uses the default parameters: a 16-bit host bus, 64-bit blocks, 64 blocks and four dummy bits. With these values it can drive junk into the upper bus bits and reach both edge blocks, 0 and 63. The zero-fill takes only 64 cycles, so reading a block that was never written is cheap. The default sizes also allow a restart request and stray write strobes to be placed in the middle of an output stream, and the bench then checks that the full 64-bit word still arrives intact.

// File: rtl/eep_pkg.sv
package eep_pkg;
  typedef enum logic [2:0] {
    ST_CLEAR,
    ST_OPC,
    ST_BLK,
    ST_WDAT,
    ST_WSTOP,
    ST_RSTOP,
    ST_DUMMY,
    ST_TDAT
  } eep_state_e;
endpackage

// File: rtl/eep_bitstore.sv
module eep_bitstore #(
  parameter int WORD_W = 64,
  parameter int BLOCKS = 64,
  localparam int AW = $clog2(BLOCKS)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [WORD_W-1:0] rdata
);
  logic [WORD_W-1:0] mem [BLOCKS];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/eep_seq.sv
module eep_seq
  import eep_pkg::*;
#(
  parameter int WORD_W     = 64,
  parameter int BLOCKS     = 64,
  parameter int DUMMY_BITS = 4,
  localparam int AW = $clog2(BLOCKS),
  localparam int CW = $clog2(WORD_W + 1),
  localparam int DW = $clog2(DUMMY_BITS + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              restart_i,
  input  logic              wr_stb_i,
  input  logic              din_i,
  input  logic              rd_stb_i,
  output logic              rd_bit_o,
  output logic              xmit_o,
  output logic              mem_we_o,
  output logic [AW-1:0]     mem_waddr_o,
  output logic [WORD_W-1:0] mem_wdata_o,
  output logic [AW-1:0]     mem_raddr_o,
  input  logic [WORD_W-1:0] mem_rdata_i
);
  eep_state_e        state;
  logic [WORD_W-1:0] rx_sh, tx_sh;
  logic [CW-1:0]     rx_cnt, tx_cnt;
  logic [DW-1:0]     dcnt;
  logic [AW-1:0]     blk, clr_idx;
  logic              is_rd, ready, rd_bit;
  logic [WORD_W-1:0] rx_next;

  assign rx_next     = {rx_sh[WORD_W-2:0], din_i};
  assign xmit_o      = (state == ST_DUMMY) || (state == ST_TDAT);
  assign rd_bit_o    = rd_bit;
  assign mem_raddr_o = blk;
  assign mem_we_o    = (state == ST_CLEAR) ||
                       ((state == ST_WDAT) && wr_stb_i && (rx_cnt == CW'(WORD_W - 1)));
  assign mem_waddr_o = (state == ST_CLEAR) ? clr_idx : blk;
  assign mem_wdata_o = (state == ST_CLEAR) ? '0 : rx_next;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_CLEAR;
      rx_sh   <= '0;
      tx_sh   <= '0;
      rx_cnt  <= '0;
      tx_cnt  <= '0;
      dcnt    <= '0;
      blk     <= '0;
      clr_idx <= '0;
      is_rd   <= 1'b0;
      ready   <= 1'b0;
      rd_bit  <= 1'b0;
    end else begin
      // status read in every non-output state
      if (rd_stb_i && !xmit_o) rd_bit <= ready;

      if (state == ST_CLEAR) begin
        clr_idx <= clr_idx + 1'b1;
        if (clr_idx == AW'(BLOCKS - 1)) state <= ST_OPC;
      end else if (restart_i && !xmit_o) begin
        state  <= ST_OPC;
        rx_sh  <= '0;
        rx_cnt <= '0;
        tx_sh  <= '0;
        tx_cnt <= '0;
        dcnt   <= '0;
      end else begin
        unique case (state)
          ST_OPC: if (wr_stb_i) begin
            if (rx_cnt == CW'(1)) begin
              rx_sh  <= '0;
              rx_cnt <= '0;
              if (rx_next[1:0] == 2'b11) begin
                is_rd <= 1'b1;
                state <= ST_BLK;
              end else if (rx_next[1:0] == 2'b10) begin
                is_rd <= 1'b0;
                state <= ST_BLK;
              end
            end else begin
              rx_sh  <= rx_next;
              rx_cnt <= rx_cnt + 1'b1;
            end
          end
          ST_BLK: if (wr_stb_i) begin
            if (rx_cnt == CW'(AW - 1)) begin
              blk    <= rx_next[AW-1:0];
              rx_sh  <= '0;
              rx_cnt <= '0;
              if (is_rd) begin
                state <= ST_RSTOP;
              end else begin
                state <= ST_WDAT;
                ready <= 1'b0;
              end
            end else begin
              rx_sh  <= rx_next;
              rx_cnt <= rx_cnt + 1'b1;
            end
          end
          ST_WDAT: if (wr_stb_i) begin
            if (rx_cnt == CW'(WORD_W - 1)) begin
              rx_sh  <= '0;
              rx_cnt <= '0;
              state  <= ST_WSTOP;
            end else begin
              rx_sh  <= rx_next;
              rx_cnt <= rx_cnt + 1'b1;
            end
          end
          ST_WSTOP: if (wr_stb_i) begin
            ready  <= 1'b1;
            rx_cnt <= '0;
            tx_cnt <= '0;
            state  <= ST_OPC;
          end
          ST_RSTOP: if (wr_stb_i) begin
            dcnt  <= '0;
            state <= ST_DUMMY;
          end
          ST_DUMMY: if (rd_stb_i) begin
            rd_bit <= 1'b0;
            if (dcnt == DW'(DUMMY_BITS - 1)) begin
              dcnt   <= '0;
              tx_sh  <= mem_rdata_i;
              tx_cnt <= '0;
              state  <= ST_TDAT;
            end else begin
              dcnt <= dcnt + 1'b1;
            end
          end
          ST_TDAT: if (rd_stb_i) begin
            rd_bit <= tx_sh[WORD_W-1];
            tx_sh  <= {tx_sh[WORD_W-2:0], 1'b0};
            if (tx_cnt == CW'(WORD_W - 1)) begin
              tx_cnt <= '0;
              rx_cnt <= '0;
              rx_sh  <= '0;
              state  <= ST_OPC;
            end else begin
              tx_cnt <= tx_cnt + 1'b1;
            end
          end
          default: state <= ST_OPC;
        endcase
      end
    end
  end
endmodule

// File: rtl/serial_eeprom_engine.sv
module serial_eeprom_engine #(
  parameter int BUS_W      = 16,
  parameter int WORD_W     = 64,
  parameter int BLOCKS     = 64,
  parameter int DUMMY_BITS = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart_i,
  input  logic             wr_stb_i,
  input  logic [BUS_W-1:0] wr_data_i,
  input  logic             rd_stb_i,
  output logic             rd_bit_o,
  output logic             xmit_o
);
  localparam int AW = $clog2(BLOCKS);

  logic              mem_we;
  logic [AW-1:0]     mem_waddr, mem_raddr;
  logic [WORD_W-1:0] mem_wdata, mem_rdata;
  logic              unused_bus_hi;

  // R1: upper bus bits carry no serial information
  assign unused_bus_hi = ^wr_data_i[BUS_W-1:1];

  eep_seq #(
    .WORD_W(WORD_W), .BLOCKS(BLOCKS), .DUMMY_BITS(DUMMY_BITS)
  ) u_seq (
    .clk(clk), .rst(rst), .restart_i(restart_i),
    .wr_stb_i(wr_stb_i), .din_i(wr_data_i[0]),
    .rd_stb_i(rd_stb_i), .rd_bit_o(rd_bit_o), .xmit_o(xmit_o),
    .mem_we_o(mem_we), .mem_waddr_o(mem_waddr), .mem_wdata_o(mem_wdata),
    .mem_raddr_o(mem_raddr), .mem_rdata_i(mem_rdata)
  );

  eep_bitstore #(
    .WORD_W(WORD_W), .BLOCKS(BLOCKS)
  ) u_store (
    .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .raddr(mem_raddr), .rdata(mem_rdata)
  );
endmodule

// File: rtl/serial_eeprom_engine_chk.sv
module serial_eeprom_engine_chk #(
  parameter int DUMMY_BITS = 4
) (
  input logic clk,
  input logic rst,
  input logic restart_i,
  input logic wr_stb_i,
  input logic rd_stb_i,
  input logic rd_bit_o,
  input logic xmit_o
);
  logic [15:0] n_rd;

  always_ff @(posedge clk) begin
    if (rst || !xmit_o) n_rd <= '0;
    else if (rd_stb_i)  n_rd <= n_rd + 1'b1;
  end

  p_restart_idle_r10: assert property (@(posedge clk) disable iff (rst)
    (restart_i && !xmit_o) |=> !xmit_o);

  p_xmit_start_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(xmit_o) |-> $past(wr_stb_i));

  p_xmit_end_r7: assert property (@(posedge clk) disable iff (rst)
    $fell(xmit_o) |-> $past(rd_stb_i));

  p_dummy_zero_r6: assert property (@(posedge clk) disable iff (rst)
    (xmit_o && rd_stb_i && (n_rd < 16'(DUMMY_BITS))) |=> (rd_bit_o == 1'b0));

  p_out_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !rd_stb_i |=> $stable(rd_bit_o));

  p_wr_ignored_r11: assert property (@(posedge clk) disable iff (rst)
    (xmit_o && wr_stb_i && !rd_stb_i) |=> (xmit_o && $stable(rd_bit_o)));
endmodule

bind serial_eeprom_engine serial_eeprom_engine_chk #(.DUMMY_BITS(DUMMY_BITS)) u_chk (
  .clk(clk), .rst(rst), .restart_i(restart_i), .wr_stb_i(wr_stb_i),
  .rd_stb_i(rd_stb_i), .rd_bit_o(rd_bit_o), .xmit_o(xmit_o)
);

// File: tb/test_serial_eeprom_engine.sv
module test_serial_eeprom_engine;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        restart_i = 1'b0;
  logic        wr_stb_i = 1'b0;
  logic [15:0] wr_data_i = '0;
  logic        rd_stb_i = 1'b0;
  logic        rd_bit_o, xmit_o;
  int          n_checks = 0;
  int          n_fail = 0;

  always #2 clk = ~clk;

  serial_eeprom_engine i_serial_eeprom_engine (
    .clk(clk), .rst(rst), .restart_i(restart_i), .wr_stb_i(wr_stb_i),
    .wr_data_i(wr_data_i), .rd_stb_i(rd_stb_i), .rd_bit_o(rd_bit_o), .xmit_o(xmit_o)
  );

  typedef struct packed {
    logic [5:0]  blk;
    logic [63:0] dat;
  } vec_t;

  localparam vec_t VEC [6] = '{
    '{6'd0,  64'h0123_4567_89AB_CDEF},
    '{6'd63, 64'hFEDC_BA98_7654_3210},
    '{6'd5,  64'h8000_0000_0000_0001},
    '{6'd17, 64'hFFFF_FFFF_FFFF_FFFF},
    '{6'd42, 64'hA5A5_5A5A_C3C3_3C3C},
    '{6'd5,  64'h0F1E_2D3C_4B5A_6978}
  };

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic put_bit(input logic b, input logic [14:0] junk);
    @(negedge clk);
    wr_stb_i  = 1'b1;
    wr_data_i = {junk, b};
    @(negedge clk);
    wr_stb_i  = 1'b0;
    wr_data_i = '0;
  endtask

  task automatic get_bit(output logic b);
    @(negedge clk);
    rd_stb_i = 1'b1;
    @(negedge clk);
    rd_stb_i = 1'b0;
    b = rd_bit_o;
  endtask

  task automatic send_head(input logic rd, input logic [5:0] blk, input logic [14:0] junk);
    put_bit(1'b1, junk);
    put_bit(rd, junk);
    for (int i = 5; i >= 0; i--) put_bit(blk[i], junk);
  endtask

  task automatic write_block(input logic [5:0] blk, input logic [63:0] d, input logic [14:0] junk);
    send_head(1'b0, blk, junk);
    for (int i = 63; i >= 0; i--) put_bit(d[i], junk);
    put_bit(1'b1, junk); // stop bit, value ignored
  endtask

  // returns dummy bits (OR) and the word
  task automatic read_block(input logic [5:0] blk, output logic dummy_or, output logic [63:0] d);
    logic b;
    send_head(1'b1, blk, 15'h0);
    put_bit(1'b0, 15'h0);
    dummy_or = 1'b0;
    for (int i = 0; i < 4; i++) begin
      get_bit(b);
      dummy_or |= b;
    end
    for (int i = 63; i >= 0; i--) begin
      get_bit(b);
      d[i] = b;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=%h expected=%h", 64'd0, 64'd1);
    $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic        b, dor;
    logic [63:0] w;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    repeat (70) @(negedge clk); // zero-fill window

    // reset state
    chk(xmit_o == 1'b0, "R9 idle after reset", {63'd0, xmit_o}, 64'd0);
    get_bit(b);
    chk(b == 1'b0, "R8 ready after reset", {63'd0, b}, 64'd0);

    // unwritten block reads zero, dummies zero, xmit framing
    send_head(1'b1, 6'd9, 15'h0);
    put_bit(1'b0, 15'h0);
    chk(xmit_o == 1'b1, "R9 xmit in dummy phase", {63'd0, xmit_o}, 64'd1);
    dor = 1'b0;
    for (int i = 0; i < 4; i++) begin get_bit(b); dor |= b; end
    chk(dor == 1'b0, "R6 dummy bits zero", {63'd0, dor}, 64'd0);
    for (int i = 63; i >= 0; i--) begin get_bit(b); w[i] = b; end
    chk(w == 64'd0, "R12 zeroed store", w, 64'd0);
    chk(xmit_o == 1'b0, "R7 idle after 64 bits", {63'd0, xmit_o}, 64'd0);

    // table walk: write, ready, read back (R3 R4 R5 R7)
    for (int v = 0; v < 6; v++) begin
      write_block(VEC[v].blk, VEC[v].dat, 15'h0);
      get_bit(b);
      chk(b == 1'b1, "R5 ready after write stop", {63'd0, b}, 64'd1);
      read_block(VEC[v].blk, dor, w);
      chk(w == VEC[v].dat && !dor, "R3 R4 R7 readback", w, VEC[v].dat);
    end
    // block 0 and 63 still intact after other writes
    read_block(6'd0, dor, w);
    chk(w == VEC[0].dat, "R3 block 0 kept", w, VEC[0].dat);
    read_block(6'd63, dor, w);
    chk(w == VEC[1].dat, "R3 block 63 kept", w, VEC[1].dat);

    // R1: junk in upper bus bits
    write_block(6'd30, 64'h1357_9BDF_0246_8ACE, 15'h7FFF);
    read_block(6'd30, dor, w);
    chk(w == 64'h1357_9BDF_0246_8ACE, "R1 only bit0 used", w, 64'h1357_9BDF_0246_8ACE);

    // R2: invalid opcode 01 then 00 is discarded
    put_bit(1'b0, 15'h0); put_bit(1'b1, 15'h0);
    put_bit(1'b0, 15'h0); put_bit(1'b0, 15'h0);
    chk(xmit_o == 1'b0, "R2 bad opcode no xmit", {63'd0, xmit_o}, 64'd0);
    read_block(6'd17, dor, w);
    chk(w == VEC[3].dat, "R2 engine back at opcode", w, VEC[3].dat);

    // R4 ready cleared after write block number, then R10 abort
    send_head(1'b0, 6'd40, 15'h0);
    for (int i = 0; i < 10; i++) put_bit(1'b1, 15'h0);
    get_bit(b);
    chk(b == 1'b0, "R4 ready cleared mid write", {63'd0, b}, 64'd0);
    @(negedge clk); restart_i = 1'b1; @(negedge clk); restart_i = 1'b0;
    get_bit(b);
    chk(b == 1'b0, "R10 restart keeps ready", {63'd0, b}, 64'd0);
    read_block(6'd40, dor, w);
    chk(w == 64'd0, "R10 aborted write not stored", w, 64'd0);

    // R10 restart ignored and R11 writes ignored while transmitting
    send_head(1'b1, 6'd63, 15'h0);
    put_bit(1'b0, 15'h0);
    for (int i = 0; i < 4; i++) get_bit(b);
    for (int i = 63; i >= 54; i--) begin get_bit(b); w[i] = b; end
    @(negedge clk); restart_i = 1'b1; @(negedge clk); restart_i = 1'b0;
    chk(xmit_o == 1'b1, "R10 restart ignored while xmit", {63'd0, xmit_o}, 64'd1);
    put_bit(1'b1, 15'h0); put_bit(1'b0, 15'h0); put_bit(1'b1, 15'h0);
    chk(xmit_o == 1'b1, "R11 writes ignored while xmit", {63'd0, xmit_o}, 64'd1);
    for (int i = 53; i >= 0; i--) begin get_bit(b); w[i] = b; end
    chk(w == VEC[1].dat, "R11 stream intact", w, VEC[1].dat);

    // R8 ready returns after a completed write
    write_block(6'd40, 64'hDEAD_BEEF_0000_0001, 15'h0);
    get_bit(b);
    chk(b == 1'b1, "R8 ready after write", {63'd0, b}, 64'd1);

    $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule